// File: doc/BRIEF.md
# Bus Address Watchpoint Unit

This block listens to the memory requests that several bus clients issue and flags any request that falls inside a programmed watch window. Four independent watch entries are provided. Each entry holds an inclusive address window, a mask of the access kinds it reacts to (read, write) and a mask of the clients it reacts to. A request that satisfies every filter of an entry is a hit for that entry. The entry then becomes pending and records what caused it: the address, the access kind, the size, the client of the first hit, and the set of clients that hit while the entry stayed pending.

Software programs and inspects the unit through a simple word-addressed register port. Writes take effect on the clock edge, and reads are combinational from the address. A global enable mask selects which pending entries may drive the single interrupt output. A status word lists the enabled pending entries and names the one to service first; the lowest-numbered entry has priority. Software can clear an entry either through that entry's own acknowledge word or through a global write-one-to-clear word. The unit only observes requests. It never stalls or blocks them.

Top module: `bus_watch_unit`

## Requirements
- R1: After reset, every configuration, capture, mask and pending bit reads as zero and `irq` is low.
- R2: An entry hits when `req_valid` is high, `lo <= req_addr <= hi`, the entry's access mask has the bit for the request kind set (bit 0 = read with `req_write`=0, bit 1 = write with `req_write`=1), and the client mask bit at index `req_client` is set. The hit sets the entry's pending bit at the clock edge. The configuration used is the one that held before that edge.
- R3: Register address bit 5 = 0 selects entry `reg_addr[4:3]`, field `reg_addr[2:0]`: 0 window low, 1 window high, 2 access mask (bits 1:0), 3 client mask (bits 13:0), 4 captured address, 5 captured client set, 6 captured detail, 7 acknowledge (reads 0). Fields 4 to 6 are read-only, and writes to them have no effect.
- R4: The first hit of an idle entry captures the address, the kind (detail bit 0, 1 = write), the first client (detail bits 7:4) and the size (detail bits 15:8), and sets the client set to the one-hot bit of the client. Later hits while the entry is pending leave the address, kind, first client and size unchanged, and OR their client bit into the client set.
- R5: Global words (bit 5 = 1, index `reg_addr[1:0]`): 0 interrupt enable mask (bits 3:0, read/write), 1 raw pending (read-only), 2 status (read-only). Status bits 3:0 are pending AND enable.
- R6: `irq` is high exactly when some entry is both pending and enabled. Clearing one enable bit does not change the pending state of any entry, nor the contribution of any other entry.
- R7: Any write to an entry's field 7, or writing 1 to bit e of global word 3, clears entry e's pending bit. Bits written as 0 in global word 3 have no effect. When an acknowledge and a hit reach the same entry in the same cycle, the acknowledge wins and the hit is dropped.
- R8: Status bits 9:8 give the lowest-numbered enabled pending entry. Bit 12 is set when any such entry exists. Both read 0 when none exists.
- R9: A client identifier of 14 or above never hits any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_client | input | 4 | Requesting client identifier |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Request size code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt, OR of enabled pending entries |

## Verification
The bench attacks the window edges, the addresses exactly at low and high and one step outside them. A design that used exclusive bounds would either miss these hits or raise false ones. It sends repeated hits from different clients to a pending entry, which exposes a capture that is overwritten rather than frozen, or a client set that is not accumulated. It sets several entries pending with mixed enables, then clears one enable and one pending bit at a time, which catches a wrong priority index, leakage of disabled entries into `irq`, and a per-entry acknowledge that clears a neighbour. A cycle in which an acknowledge and a hit arrive together shows whether the design lets the hit survive. Client identifiers 14 and 15 show whether the client mask is indexed out of range.

// File: rtl/bwu_pkg.sv
package bwu_pkg;
   typedef enum logic [2:0] {
      FLD_LO       = 3'd0,
      FLD_HI       = 3'd1,
      FLD_OPS      = 3'd2,
      FLD_CLIENTS  = 3'd3,
      FLD_CAP_ADDR = 3'd4,
      FLD_CAP_SET  = 3'd5,
      FLD_CAP_INFO = 3'd6,
      FLD_ACK      = 3'd7
   } entry_fld_e;

   typedef enum logic [1:0] {
      GLB_MASK = 2'd0,
      GLB_RAW  = 2'd1,
      GLB_STAT = 2'd2,
      GLB_ACK  = 2'd3
   } glb_fld_e;

   localparam int INFO_OP_BIT    = 0;
   localparam int INFO_FIRST_LSB = 4;
   localparam int INFO_SIZE_LSB  = 8;
   localparam int STAT_IDX_LSB   = 8;
   localparam int STAT_ANY_BIT   = 12;
endpackage

// File: rtl/bwu_entry.sv
module bwu_entry
   import bwu_pkg::*;
#(
   parameter int AW            = 32,
   parameter int DW            = 32,
   parameter int NCLIENT       = 14,
   parameter int SW            = 3,
   parameter bit ACCUM_CLIENTS = 1'b1,
   localparam int CIDW         = $clog2(NCLIENT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_fld,
   input  logic [DW-1:0]      wdata,
   input  logic               ack,
   input  logic               req_valid,
   input  logic [AW-1:0]      req_addr,
   input  logic [CIDW-1:0]    req_client,
   input  logic               req_write,
   input  logic [SW-1:0]      req_size,
   output logic               hit,
   output logic               pend,
   output logic [AW-1:0]      cap_addr,
   output logic [DW-1:0]      rd_data
);
   logic [AW-1:0]      lo_q, hi_q;
   logic [1:0]         ops_q;
   logic [NCLIENT-1:0] cmask_q;
   logic               cap_op_q;
   logic [CIDW-1:0]    cap_first_q;
   logic [SW-1:0]      cap_size_q;
   logic [NCLIENT-1:0] cap_set_q;
   logic [NCLIENT-1:0] client_oh;
   logic               take_first;
   logic               unused_wdata;

   assign unused_wdata = ^wdata;

   always_comb begin
      client_oh = '0;
      for (int c = 0; c < NCLIENT; c++) begin
         if (req_client == CIDW'(c)) client_oh[c] = 1'b1;
      end
   end

   assign hit = req_valid && (req_addr >= lo_q) && (req_addr <= hi_q)
                && ops_q[req_write] && (|(cmask_q & client_oh));

   assign take_first = hit && !ack && !pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q    <= '0;
         hi_q    <= '0;
         ops_q   <= '0;
         cmask_q <= '0;
      end else if (cfg_we) begin
         case (entry_fld_e'(cfg_fld))
            FLD_LO:      lo_q    <= wdata[AW-1:0];
            FLD_HI:      hi_q    <= wdata[AW-1:0];
            FLD_OPS:     ops_q   <= wdata[1:0];
            FLD_CLIENTS: cmask_q <= wdata[NCLIENT-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend        <= 1'b0;
         cap_addr    <= '0;
         cap_op_q    <= 1'b0;
         cap_first_q <= '0;
         cap_size_q  <= '0;
      end else if (ack) begin
         pend <= 1'b0;
      end else if (take_first) begin
         pend        <= 1'b1;
         cap_addr    <= req_addr;
         cap_op_q    <= req_write;
         cap_first_q <= req_client;
         cap_size_q  <= req_size;
      end
   end

   generate
      if (ACCUM_CLIENTS) begin : g_accumulate
         always_ff @(posedge clk) begin
            if (!rst_n)            cap_set_q <= '0;
            else if (take_first)   cap_set_q <= client_oh;
            else if (hit && !ack)  cap_set_q <= cap_set_q | client_oh;
         end
      end else begin : g_first_only
         always_ff @(posedge clk) begin
            if (!rst_n)            cap_set_q <= '0;
            else if (take_first)   cap_set_q <= client_oh;
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      case (entry_fld_e'(cfg_fld))
         FLD_LO:       rd_data = DW'(lo_q);
         FLD_HI:       rd_data = DW'(hi_q);
         FLD_OPS:      rd_data = DW'(ops_q);
         FLD_CLIENTS:  rd_data = DW'(cmask_q);
         FLD_CAP_ADDR: rd_data = DW'(cap_addr);
         FLD_CAP_SET:  rd_data = DW'(cap_set_q);
         FLD_CAP_INFO: begin
            rd_data[INFO_OP_BIT]                     = cap_op_q;
            rd_data[INFO_FIRST_LSB +: CIDW]          = cap_first_q;
            rd_data[INFO_SIZE_LSB +: SW]             = cap_size_q;
         end
         default:      rd_data = '0;
      endcase
   end
endmodule

// File: rtl/bwu_irq.sv
module bwu_irq
   import bwu_pkg::*;
#(
   parameter int N_WATCH = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mask_we,
   input  logic [N_WATCH-1:0] mask_wdata,
   input  logic [N_WATCH-1:0] pend,
   output logic [N_WATCH-1:0] mask_q,
   output logic [N_WATCH-1:0] masked,
   output logic [1:0]         top_idx,
   output logic               top_any,
   output logic               irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_wdata;
   end

   assign masked  = pend & mask_q;
   assign top_any = |masked;
   assign irq     = top_any;

   always_comb begin
      top_idx = '0;
      for (int i = N_WATCH - 1; i >= 0; i--) begin
         if (masked[i]) top_idx = 2'(i);
      end
   end
endmodule

// File: rtl/bus_watch_unit.sv
module bus_watch_unit
   import bwu_pkg::*;
#(
   parameter int N_WATCH       = 4,
   parameter int AW            = 32,
   parameter int DW            = 32,
   parameter int NCLIENT       = 14,
   parameter int SW            = 3,
   parameter int RAW           = 6,
   parameter bit ACCUM_CLIENTS = 1'b1,
   localparam int CIDW         = $clog2(NCLIENT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [AW-1:0]   req_addr,
   input  logic [CIDW-1:0] req_client,
   input  logic            req_write,
   input  logic [SW-1:0]   req_size,
   input  logic            reg_wr,
   input  logic [RAW-1:0]  reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   output logic            irq
);
   if (N_WATCH < 1 || N_WATCH > 4) begin : g_bad_nwatch
      $error("N_WATCH must be 1..4");
   end
   if (AW > DW) begin : g_bad_aw
      $error("AW must not exceed DW");
   end
   if (NCLIENT < 2 || NCLIENT > 16 || NCLIENT > DW) begin : g_bad_nclient
      $error("NCLIENT must be 2..16");
   end
   if (SW < 1 || SW > 8) begin : g_bad_sw
      $error("SW must be 1..8");
   end
   if (RAW != 6) begin : g_bad_raw
      $error("RAW must be 6");
   end

   logic                        is_glb;
   logic [1:0]                  ent_sel;
   logic [2:0]                  ent_fld;
   logic [1:0]                  glb_fld;
   logic [N_WATCH-1:0]          cfg_we, ack_w, hit_w, pend_w;
   logic [N_WATCH-1:0][AW-1:0]  cap_addr_w;
   logic [N_WATCH-1:0][DW-1:0]  ent_rd;
   logic [N_WATCH-1:0]          mask_q, masked_w;
   logic [1:0]                  top_idx;
   logic                        top_any;
   logic                        glb_ack_we;
   logic [DW-1:0]               glb_rd;

   assign is_glb     = reg_addr[5];
   assign ent_sel    = reg_addr[4:3];
   assign ent_fld    = reg_addr[2:0];
   assign glb_fld    = reg_addr[1:0];
   assign glb_ack_we = reg_wr && is_glb && (glb_fld_e'(glb_fld) == GLB_ACK);

   generate
      for (genvar e = 0; e < N_WATCH; e++) begin : g_entry
         assign cfg_we[e] = reg_wr && !is_glb && (ent_sel == 2'(e));
         assign ack_w[e]  = (cfg_we[e] && (entry_fld_e'(ent_fld) == FLD_ACK))
                            || (glb_ack_we && reg_wdata[e]);

         bwu_entry #(
            .AW(AW), .DW(DW), .NCLIENT(NCLIENT), .SW(SW),
            .ACCUM_CLIENTS(ACCUM_CLIENTS)
         ) i_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we[e]),
            .cfg_fld    (ent_fld),
            .wdata      (reg_wdata),
            .ack        (ack_w[e]),
            .req_valid  (req_valid),
            .req_addr   (req_addr),
            .req_client (req_client),
            .req_write  (req_write),
            .req_size   (req_size),
            .hit        (hit_w[e]),
            .pend       (pend_w[e]),
            .cap_addr   (cap_addr_w[e]),
            .rd_data    (ent_rd[e])
         );
      end
   endgenerate

   bwu_irq #(.N_WATCH(N_WATCH)) i_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_we    (reg_wr && is_glb && (glb_fld_e'(glb_fld) == GLB_MASK)),
      .mask_wdata (reg_wdata[N_WATCH-1:0]),
      .pend       (pend_w),
      .mask_q     (mask_q),
      .masked     (masked_w),
      .top_idx    (top_idx),
      .top_any    (top_any),
      .irq        (irq)
   );

   always_comb begin
      glb_rd = '0;
      case (glb_fld_e'(glb_fld))
         GLB_MASK: glb_rd = DW'(mask_q);
         GLB_RAW:  glb_rd = DW'(pend_w);
         GLB_STAT: begin
            glb_rd[N_WATCH-1:0]          = masked_w;
            glb_rd[STAT_IDX_LSB +: 2]    = top_idx;
            glb_rd[STAT_ANY_BIT]         = top_any;
         end
         default:  glb_rd = '0;
      endcase
   end

   always_comb begin
      reg_rdata = '0;
      if (is_glb) begin
         reg_rdata = glb_rd;
      end else begin
         for (int e = 0; e < N_WATCH; e++) begin
            if (ent_sel == 2'(e)) reg_rdata = ent_rd[e];
         end
      end
   end
endmodule

// File: rtl/bwu_checker.sv
module bwu_checker #(
   parameter int N_WATCH = 4,
   parameter int AW      = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       irq,
   input logic [N_WATCH-1:0]         pend,
   input logic [N_WATCH-1:0]         mask,
   input logic [N_WATCH-1:0]         hit,
   input logic [N_WATCH-1:0]         ack,
   input logic [N_WATCH-1:0][AW-1:0] cap_addr
);
   a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((|mask) && (|pend)));

   a_r1_irq_low_in_reset: assert property (@(posedge clk)
      !rst_n |=> !irq);

   generate
      for (genvar e = 0; e < N_WATCH; e++) begin : g_chk
         a_r2_hit_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[e] && !ack[e]) |=> pend[e]);
         a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            ack[e] |=> !pend[e]);
         a_r7_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit[e] && !ack[e]) |=> $stable(pend[e]));
         a_r4_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[e] && !ack[e]) |=> $stable(cap_addr[e]));
      end
   endgenerate
endmodule

bind bus_watch_unit bwu_checker #(.N_WATCH(N_WATCH), .AW(AW)) i_bwu_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq      (irq),
   .pend     (pend_w),
   .mask     (mask_q),
   .hit      (hit_w),
   .ack      (ack_w),
   .cap_addr (cap_addr_w)
);

// File: tb/test_bus_watch_unit.sv
`timescale 1ns/1ps
module test_bus_watch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_client = '0;
   logic        req_write = 1'b0;
   logic [2:0]  req_size = '0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [31:0] m_lo [4], m_hi [4], m_caddr [4];
   logic [1:0]  m_ops [4];
   logic [13:0] m_cm [4], m_cset [4];
   logic        m_cop [4];
   logic [3:0]  m_cfirst [4];
   logic [2:0]  m_csz [4];
   logic [3:0]  m_pend, m_mask;

   always #2 clk = ~clk;

   bus_watch_unit i_bus_watch_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_client(req_client), .req_write(req_write), .req_size(req_size),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] m_read(logic [5:0] a);
      logic [31:0] r = '0;
      int e = int'(a[4:3]);
      logic [3:0] mk = m_pend & m_mask;
      if (a[5]) begin
         case (a[1:0])
            2'd0: r = {28'd0, m_mask};
            2'd1: r = {28'd0, m_pend};
            2'd2: begin
               r[3:0] = mk;
               for (int i = 3; i >= 0; i--) if (mk[i]) r[9:8] = 2'(i);
               r[12] = |mk;
            end
            default: r = '0;
         endcase
      end else begin
         case (a[2:0])
            3'd0: r = m_lo[e];
            3'd1: r = m_hi[e];
            3'd2: r = {30'd0, m_ops[e]};
            3'd3: r = {18'd0, m_cm[e]};
            3'd4: r = m_caddr[e];
            3'd5: r = {18'd0, m_cset[e]};
            3'd6: begin r[0] = m_cop[e]; r[7:4] = m_cfirst[e]; r[10:8] = m_csz[e]; end
            default: r = '0;
         endcase
      end
      return r;
   endfunction

   function automatic bit m_hit(int e, logic [31:0] a, logic [3:0] c, logic w);
      return m_ops[e][w] && (a >= m_lo[e]) && (a <= m_hi[e]) && (c < 4'd14) && m_cm[e][c];
   endfunction

   // one clock: optional request and optional register write in the same cycle
   task automatic step(bit da, logic [31:0] a, logic [3:0] c, logic w, logic [2:0] s,
                       bit dw, logic [5:0] ra, logic [31:0] rd);
      logic [3:0] acks = '0;
      @(negedge clk);
      req_valid = da; req_addr = a; req_client = c; req_write = w; req_size = s;
      reg_wr = dw; reg_addr = ra; reg_wdata = rd;
      if (dw) begin
         if (!ra[5] && ra[2:0] == 3'd7) acks[ra[4:3]] = 1'b1;
         if (ra[5] && ra[1:0] == 2'd3) acks = rd[3:0];
      end
      for (int e = 0; e < 4; e++) begin
         if (acks[e]) m_pend[e] = 1'b0;
         else if (da && m_hit(e, a, c, w)) begin
            if (!m_pend[e]) begin
               m_pend[e] = 1'b1; m_caddr[e] = a; m_cop[e] = w;
               m_cfirst[e] = c; m_csz[e] = s; m_cset[e] = 14'(1) << c;
            end else m_cset[e] = m_cset[e] | (14'(1) << c);
         end
      end
      if (dw && ra[5] && ra[1:0] == 2'd0) m_mask = rd[3:0];
      if (dw && !ra[5]) begin
         case (ra[2:0])
            3'd0: m_lo[ra[4:3]]  = rd;
            3'd1: m_hi[ra[4:3]]  = rd;
            3'd2: m_ops[ra[4:3]] = rd[1:0];
            3'd3: m_cm[ra[4:3]]  = rd[13:0];
            default: ;
         endcase
      end
      @(posedge clk); #1;
      req_valid = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic wr(logic [5:0] ra, logic [31:0] rd);
      step(0, '0, '0, 0, '0, 1, ra, rd);
   endtask

   task automatic acc(logic [31:0] a, logic [3:0] c, logic w, logic [2:0] s);
      step(1, a, c, w, s, 0, '0, '0);
   endtask

   task automatic rd_check(string tag, logic [5:0] ra);
      @(negedge clk);
      reg_addr = ra; #1;
      check(tag, reg_rdata, m_read(ra));
   endtask

   task automatic irq_check(string tag);
      check(tag, {31'd0, irq}, {31'd0, |(m_pend & m_mask)});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got hang expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      for (int e = 0; e < 4; e++) begin
         m_lo[e] = 0; m_hi[e] = 0; m_caddr[e] = 0; m_ops[e] = 0; m_cm[e] = 0;
         m_cset[e] = 0; m_cop[e] = 0; m_cfirst[e] = 0; m_csz[e] = 0;
      end
      m_pend = 0; m_mask = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 64; a++) rd_check("R1 reset readback", 6'(a));
      irq_check("R1 irq after reset");

      // R3 config readback; entry 0 window 0x100..0x1FF, reads, client 3
      wr(6'd0, 32'h100); wr(6'd1, 32'h1FF); wr(6'd2, 32'h1); wr(6'd3, 32'h8);
      for (int a = 0; a < 4; a++) rd_check("R3 entry0 config", 6'(a));
      wr(6'd4, 32'hDEAD); wr(6'd6, 32'hFFFF); wr(6'h21, 32'hF);
      rd_check("R3 capture addr read-only", 6'd4);
      rd_check("R3 capture info read-only", 6'd6);
      rd_check("R5 raw pending read-only", 6'h21);

      // R2 boundaries and filters (no hit expected)
      acc(32'h0FF, 4'd3, 0, 3'd2); acc(32'h200, 4'd3, 0, 3'd2);
      acc(32'h150, 4'd3, 1, 3'd2); acc(32'h150, 4'd4, 0, 3'd2);
      rd_check("R2 no hit outside filters", 6'h21);
      // R9 out-of-range client
      wr(6'd3, 32'h3FFF);
      acc(32'h150, 4'd14, 0, 3'd1); acc(32'h150, 4'd15, 0, 3'd1);
      rd_check("R9 client 14/15 ignored", 6'h21);
      wr(6'd3, 32'h8);

      // R2 hit at upper bound, R5 masked off
      acc(32'h1FF, 4'd3, 0, 3'd5);
      rd_check("R2 hit at hi bound", 6'h21);
      rd_check("R5 status with mask off", 6'h22);
      irq_check("R6 irq low when disabled");
      wr(6'h20, 32'h1);
      irq_check("R6 irq high when enabled");
      rd_check("R4 first capture addr", 6'd4);
      rd_check("R4 first capture info", 6'd6);

      // R4 frozen capture, accumulated client set
      wr(6'd3, 32'h28);
      acc(32'h100, 4'd5, 0, 3'd1);
      rd_check("R4 addr frozen", 6'd4);
      rd_check("R4 info frozen", 6'd6);
      rd_check("R4 client set accumulates", 6'd5);

      // R8 priority with entries 1 and 2
      wr(6'd8, 32'h0);  wr(6'd9, 32'hFFFF);  wr(6'd10, 32'h3); wr(6'd11, 32'h3FFF);
      wr(6'd16, 32'h0); wr(6'd17, 32'hFFFF); wr(6'd18, 32'h2); wr(6'd19, 32'h3FFF);
      acc(32'h50, 4'd7, 1, 3'd3);
      wr(6'h20, 32'h6);
      rd_check("R8 top index entry1", 6'h22);
      wr(6'h20, 32'h4);
      rd_check("R8 top index entry2 after disable", 6'h22);
      rd_check("R6 disable keeps pending", 6'h21);
      irq_check("R6 irq from other entry");

      // R7 per-entry ack, global ack with zero bits, ack beats hit
      wr(6'd15, 32'h0);
      rd_check("R7 per-entry ack entry1", 6'h21);
      wr(6'h23, 32'h0);
      rd_check("R7 zero bits no effect", 6'h21);
      step(1, 32'h60, 4'd2, 1, 3'd0, 1, 6'h23, 32'h4);
      rd_check("R7 ack wins over hit", 6'h21);
      irq_check("R7 irq after ack");
      wr(6'h23, 32'hF);
      rd_check("R7 global ack all", 6'h21);
      wr(6'h20, 32'hF);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int k = int'($urandom % 100);
         if (k < 60) begin
            acc($urandom % 96, 4'($urandom), 1'($urandom), 3'($urandom));
         end else if (k < 78) begin
            logic [5:0] ra = {1'b0, 2'($urandom), 3'($urandom % 4)};
            wr(ra, (ra[2:1] == 2'd0) ? ($urandom % 96) : $urandom);
         end else if (k < 84) begin
            wr({1'b0, 2'($urandom), 3'd7}, $urandom);
         end else if (k < 88) begin
            wr(6'h23, $urandom);
         end else if (k < 91) begin
            wr(6'h20, $urandom);
         end else if (k < 93) begin
            wr(6'($urandom), $urandom);
         end else begin
            rd_check("R3 R4 R5 R8 random readback", 6'($urandom));
         end
         irq_check("R6 random irq");
      end
      for (int a = 0; a < 64; a++) rd_check("R4 R5 final readback", 6'(a));

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule